// File: doc/BRIEF.md
# Serial Magnitude Comparator, Most Significant Bit First

This block decides which of two unsigned numbers of equal length is larger. The two numbers arrive one bit per clock, most significant bit first, on two single-bit inputs. While every pair seen so far has matched, the block reports "equal". The first pair that differs settles the verdict. That verdict then stays fixed for the rest of the operand, and later bits cannot change it.

A one-cycle `start` pulse opens a new comparison. The pair presented in the cycle that carries `start` is compared as the most significant bit of the new operands, so no idle cycle is needed between operands. The block does not count operand length. The user decides when the last bit has gone in and reads the verdict one clock later. The outputs come straight from flops, so they show every pair consumed up to and including the previous clock edge.

A parameter chooses how the three-way verdict is stored. The default is a packed two-flop code whose bits are the outputs themselves. The alternative is a three-flop one-hot code. Both give the same behaviour at the ports.

Top module: `ser_mag_cmp`

## Requirements
- R1: A clock edge with `start` high discards any earlier verdict. The pair on `bit_a`/`bit_b` in that cycle is compared as the first bit, so after that edge the outputs depend only on that pair.
- R2: While the verdict is equal, a pair with `bit_a` equal to `bit_b` (00 or 11) keeps both outputs low after the edge.
- R3: While the verdict is equal, the pair `bit_a`=1, `bit_b`=0 gives `a_big`=1, `b_big`=0 after the edge.
- R4: While the verdict is equal, the pair `bit_a`=0, `bit_b`=1 gives `a_big`=0, `b_big`=1 after the edge.
- R5: Once `a_big` or `b_big` is high, that output stays high and the other stays low for every input pair until an edge with `start` high.
- R6: From the first edge with `start` high onward, `a_big` and `b_big` are never high together. The verdict encoding at the ports is {`a_big`,`b_big`}: 00 equal, 10 A larger, 01 B larger.
- R7: Suppose two N-bit unsigned operands are fed most significant bit first, with `start` on the first bit. One edge after the last bit, the outputs match the numeric comparison of the operands. After each intermediate bit, they match the comparison of the prefixes consumed so far.
- R8: Asserting `start` while a verdict is locked restarts the comparison at once. A differing first pair produces the opposite verdict in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| start | input | 1 | Synchronous: begins a new comparison with the current pair as first bit |
| bit_a | input | 1 | Serial bit of operand A, most significant first |
| bit_b | input | 1 | Serial bit of operand B, most significant first |
| a_big | output | 1 | High when A is found larger |
| b_big | output | 1 | High when B is found larger |

## Verification
Every verdict falls due exactly one rising edge after the pair that decides it, because the only register between the inputs and the outputs is the verdict register itself. The bench changes the inputs, waits for one rising edge, then samples a quarter period later. It never samples on an edge. It then checks the outputs against the verdict it computes itself from the prefix of bits fed so far. The final check after the last bit of each 8-bit or 16-bit operand pair therefore compares against the plain numeric relation of the two operands.

// File: rtl/smc_pkg.sv
package smc_pkg;

   // Port-visible code: bit 1 drives a_big, bit 0 drives b_big.
   typedef enum logic [1:0] {
      V_EQ  = 2'b00,
      V_AGT = 2'b10,
      V_BGT = 2'b01
   } verdict_e;

   localparam int unsigned ENC_PACKED = 0;
   localparam int unsigned ENC_ONEHOT = 1;

   // The first differing pair settles the verdict; a settled verdict sticks.
   function automatic verdict_e next_verdict(verdict_e cur, logic a, logic b);
      if (cur != V_EQ) return cur;
      if (a && !b)     return V_AGT;
      if (!a && b)     return V_BGT;
      return V_EQ;
   endfunction

endpackage

// File: rtl/smc_decide.sv
module smc_decide
   import smc_pkg::*;
(
   input  verdict_e cur,
   input  logic     start,
   input  logic     bit_a,
   input  logic     bit_b,
   output verdict_e nxt
);

   verdict_e base;

   // A new comparison sees the current pair against a clean equal verdict.
   always_comb begin
      base = start ? V_EQ : cur;
      nxt  = next_verdict(base, bit_a, bit_b);
   end

endmodule

// File: rtl/smc_state.sv
module smc_state
   import smc_pkg::*;
#(
   parameter int unsigned ENC = ENC_PACKED
)(
   input  logic     clk,
   input  verdict_e nxt,
   output verdict_e cur
);

   localparam int unsigned NFLOP = (ENC == ENC_ONEHOT) ? 3 : 2;

   generate
      if (ENC != ENC_PACKED && ENC != ENC_ONEHOT) begin : g_bad_enc
         $error("smc_state: ENC must be 0 (packed) or 1 (one-hot)");
      end

      if (ENC == ENC_ONEHOT) begin : g_onehot
         logic [NFLOP-1:0] oh;   // [2]=A larger, [1]=B larger, [0]=equal
         always_ff @(posedge clk) begin
            oh <= {nxt == V_AGT, nxt == V_BGT, nxt == V_EQ};
         end
         always_comb begin
            if (oh[2])      cur = V_AGT;
            else if (oh[1]) cur = V_BGT;
            else            cur = V_EQ;
         end
      end else begin : g_packed
         logic [NFLOP-1:0] q;
         always_ff @(posedge clk) begin
            q <= nxt;
         end
         assign cur = verdict_e'(q);
      end
   endgenerate

endmodule

// File: rtl/ser_mag_cmp.sv
module ser_mag_cmp
   import smc_pkg::*;
#(
   parameter int unsigned ENC = ENC_PACKED
)(
   input  logic clk,
   input  logic start,
   input  logic bit_a,
   input  logic bit_b,
   output logic a_big,
   output logic b_big
);

   verdict_e cur;
   verdict_e nxt;

   smc_decide u_decide (
      .cur   (cur),
      .start (start),
      .bit_a (bit_a),
      .bit_b (bit_b),
      .nxt   (nxt)
   );

   smc_state #(.ENC(ENC)) u_state (
      .clk (clk),
      .nxt (nxt),
      .cur (cur)
   );

   assign a_big = cur[1];
   assign b_big = cur[0];

endmodule

// File: rtl/ser_mag_cmp_chk.sv
module ser_mag_cmp_chk (
   input logic clk,
   input logic start,
   input logic bit_a,
   input logic bit_b,
   input logic a_big,
   input logic b_big
);

   logic primed = 1'b0;
   logic live;

   always_ff @(posedge clk) begin
      if (start) primed <= 1'b1;
   end

   assign live = primed | start;

   AST_START_SAME: assert property (@(posedge clk) disable iff (!live)
      (start && (bit_a == bit_b)) |=> (!a_big && !b_big));                           // R1
   AST_EQ_STAYS: assert property (@(posedge clk) disable iff (!live)
      (!start && !a_big && !b_big && (bit_a == bit_b)) |=> (!a_big && !b_big));      // R2
   AST_A_WINS: assert property (@(posedge clk) disable iff (!live)
      ((start || (!a_big && !b_big)) && bit_a && !bit_b) |=> (a_big && !b_big));     // R3
   AST_B_WINS: assert property (@(posedge clk) disable iff (!live)
      ((start || (!a_big && !b_big)) && !bit_a && bit_b) |=> (!a_big && b_big));     // R4
   AST_HOLD_A: assert property (@(posedge clk) disable iff (!live)
      (!start && a_big) |=> (a_big && !b_big));                                      // R5
   AST_HOLD_B: assert property (@(posedge clk) disable iff (!live)
      (!start && b_big) |=> (b_big && !a_big));                                      // R5
   AST_NO_BOTH: assert property (@(posedge clk) disable iff (!primed)
      !(a_big && b_big));                                                            // R6
   AST_RESTART: assert property (@(posedge clk) disable iff (!live)
      (start && a_big && !bit_a && bit_b) |=> b_big);                                // R8

endmodule

bind ser_mag_cmp ser_mag_cmp_chk u_chk (
   .clk   (clk),
   .start (start),
   .bit_a (bit_a),
   .bit_b (bit_b),
   .a_big (a_big),
   .b_big (b_big)
);

// File: tb/sim_ser_mag_cmp.sv
module sim_ser_mag_cmp;

   localparam int PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 100000;

   logic clk = 1'b0;
   logic start = 1'b0;
   logic bit_a = 1'b0;
   logic bit_b = 1'b0;
   logic a_big;
   logic b_big;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   ser_mag_cmp u0 (
      .clk   (clk),
      .start (start),
      .bit_a (bit_a),
      .bit_b (bit_b),
      .a_big (a_big),
      .b_big (b_big)
   );

   // Expected {a_big,b_big}: 10 A larger, 01 B larger, 00 equal.
   function automatic logic [1:0] ref_cmp(logic [15:0] a, logic [15:0] b);
      if (a > b) return 2'b10;
      if (a < b) return 2'b01;
      return 2'b00;
   endfunction

   task automatic check(string req, logic [1:0] exp);
      checks++;
      if ({a_big, b_big} !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", req, {a_big, b_big}, exp, $time);
      end
   endtask

   // Drive one pair, let one rising edge pass, sample a quarter period after it.
   task automatic step(logic st, logic a, logic b);
      start = st;
      bit_a = a;
      bit_b = b;
      @(posedge clk);
      #(PERIOD/4);
      start = 1'b0;
   endtask

   task automatic run_pair(int n, logic [15:0] a, logic [15:0] b, string req);
      for (int i = n - 1; i >= 0; i--) begin
         step(i == n - 1, a[i], b[i]);
         check("R7 prefix", ref_cmp(a >> i, b >> i));
      end
      check(req, ref_cmp(a, b));
   endtask

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      @(negedge clk);

      // R1: start with equal pair gives equal verdict
      step(1'b1, 1'b0, 1'b0);
      check("R1 start equal", 2'b00);
      // R2: matching pairs keep equal
      step(1'b0, 1'b1, 1'b1);
      check("R2 pair 11", 2'b00);
      step(1'b0, 1'b0, 1'b0);
      check("R2 pair 00", 2'b00);
      // R3: A larger locks
      step(1'b0, 1'b1, 1'b0);
      check("R3 a wins", 2'b10);
      // R5: locked verdict ignores every pair
      step(1'b0, 1'b0, 1'b1);
      check("R5 hold A vs 01", 2'b10);
      step(1'b0, 1'b1, 1'b1);
      check("R5 hold A vs 11", 2'b10);
      step(1'b0, 1'b0, 1'b0);
      check("R5 hold A vs 00", 2'b10);
      // R8: restart while locked, opposite first pair
      step(1'b1, 1'b0, 1'b1);
      check("R8 restart to B", 2'b01);
      // R4 path from equal; R5 hold for B
      step(1'b1, 1'b1, 1'b1);
      check("R1 restart equal", 2'b00);
      step(1'b0, 1'b0, 1'b1);
      check("R4 b wins", 2'b01);
      step(1'b0, 1'b1, 1'b0);
      check("R5 hold B vs 10", 2'b01);
      // R1: start with differing pair decides at once
      step(1'b1, 1'b1, 1'b0);
      check("R1 start decides", 2'b10);

      // Directed operand corners
      run_pair(8, 16'h00FF, 16'h00FF, "R7 equal 8b");
      run_pair(8, 16'h0080, 16'h007F, "R7 msb 8b");
      run_pair(8, 16'h00FE, 16'h00FF, "R7 lsb 8b");
      run_pair(16, 16'h0000, 16'h0000, "R7 zeros 16b");
      run_pair(16, 16'h7FFF, 16'h8000, "R7 msb 16b");

      // Constrained random: 8-bit and 16-bit, some forced equal
      for (int k = 0; k < 200; k++) begin
         logic [15:0] a, b;
         int n;
         n = ($urandom % 2) ? 16 : 8;
         a = 16'($urandom);
         b = 16'($urandom);
         if (n == 8) begin
            a = a & 16'h00FF;
            b = b & 16'h00FF;
         end
         if ($urandom % 4 == 0) b = a;
         else if ($urandom % 4 == 0) b = a ^ (16'h1 << ($urandom % n));
         run_pair(n, a, b, "R7 random");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule